// File: doc/BRIEF.md
# Serial Radix-2 FFT Pipeline Stage

This block is one stage of a streaming, decimation-in-frequency FFT. It accepts one complex sample on each beat where `in_valid` is high and produces one complex sample per accepted beat. Inside are four pieces:

- a delay memory of D = N/2^(STAGE+1) complex words;
- a butterfly that computes a sum and a difference;
- a constant-coefficient twiddle multiplier;
- a two-way switch.

Each block of 2·D beats has two halves. In the first half, the switch loads the new samples into the delay memory and sends the memory's old contents to the output. In the second half, the switch pairs each new sample with the one stored D beats earlier. The halved sum goes to the output. The twiddled, halved difference goes back into the memory, and it leaves the stage during the first half of the next block.

Every result is halved and rounded, so the output format has one more integer bit and one fewer fractional bit than the input. Only the scale factor matters, so the stage is independent of where the binary point sits. A difference that leaves the 18-bit range after the twiddle multiply is clamped to the nearest limit. Stages are chained with STAGE running from 0 to LOG2N-1. To drain the last block's differences, the user feeds D more beats, which may be zeros.

Top module: `sdf_fft_stage`

## Requirements
- R1: The stage has one register on its output path. `out_valid` is high exactly one cycle after a beat with `in_valid` high, unless R2 holds. A sample that enters at accepted beat k reaches the output D accepted beats later, either as part of a sum or as part of a difference.
- R2: After reset, the first D accepted beats (the first fill half) produce no `out_valid`.
- R3: Beat j in the second half is the one D beats after the stored sample a; its input is b. For that beat the output is floor((a+b+1)/2), computed separately on the real and imaginary parts.
- R4: For second-half position n (0 to D-1), the value (a−b)·W is stored. At position n of the next first half it is output as floor((p·2^TWF + 2^TWF)/2^(TWF+1)), where p is the product per part. Outputs keep the order n = 0..D−1.
- R5: A twiddled difference above +131071 is output as +131071. One below −131072 is output as −131072.
- R6: A cycle with `in_valid` low does not advance the block position or the delay memory. `out_valid` is low on the next cycle and `out_re`/`out_im` hold their previous value.
- R7: A synchronous, active-high `rst` clears `out_valid`, `out_re` and `out_im` to 0 on the next cycle and returns the stage to the start of a fill half.
- R8: The twiddle for position n is W = cos(2π·n·2^STAGE/N) − j·sin(2π·n·2^STAGE/N). Each part is stored as a signed TW_W-bit value with TW_F fractional bits, so 1.0 is 65536 at the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input sample is present this cycle |
| in_re | input | 18 | Input real part, signed |
| in_im | input | 18 | Input imaginary part, signed |
| out_valid | output | 1 | An output sample is present this cycle |
| out_re | output | 18 | Output real part, signed, scaled by 1/2 |
| out_im | output | 18 | Output imaginary part, signed, scaled by 1/2 |

## Verification
Several checks hold on every clock:
- output valid only follows an accepted beat;
- nothing is valid during the unprimed fill half;
- idle cycles freeze the block position and the output;
- fill-half outputs equal the delay memory's head;
- a clamped difference sits exactly at the limit.

Other behaviour depends on values across a whole block, so only the bench scenarios can show it:
- the numeric pairing of samples D beats apart;
- the rounding of sums and differences;
- the effect of the −j twiddle;
- order preservation across a stall;
- the restart position after a mid-block reset.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
    localparam int DW   = 18;
    localparam int WIDE = 48;

    typedef logic signed [DW-1:0]   samp_t;
    typedef logic signed [WIDE-1:0] wide_t;

    typedef struct packed {
        samp_t re;
        samp_t im;
    } cplx_t;

    localparam samp_t SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam samp_t SMIN = {1'b1, {(DW-1){1'b0}}};
    localparam wide_t WMAX = {{(WIDE-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam wide_t WMIN = {{(WIDE-DW+1){1'b1}}, {(DW-1){1'b0}}};

    function automatic wide_t widen(input samp_t v);
        return {{(WIDE-DW){v[DW-1]}}, v};
    endfunction

    function automatic samp_t clamp(input wide_t v);
        if (v > WMAX)      return SMAX;
        else if (v < WMIN) return SMIN;
        else               return v[DW-1:0];
    endfunction
endpackage

// File: rtl/sdf_twiddle_rom.sv
module sdf_twiddle_rom #(
    parameter int LOG2N = 4,
    parameter int STAGE = 0,
    parameter int AW    = 3,
    parameter int TW_W  = 18,
    parameter int TW_F  = 16
) (
    input  logic [AW-1:0]          idx,
    output logic signed [TW_W-1:0] w_re,
    output logic signed [TW_W-1:0] w_im
);
    localparam int ENTRIES = 1 << AW;
    localparam real PI     = 3.14159265358979323846;

    function automatic logic signed [TW_W-1:0] coef(input int k, input bit want_sine);
        real ang;
        real v;
        int  q;
        ang = 2.0 * PI * real'(k) / (2.0 ** LOG2N);
        v   = want_sine ? -$sin(ang) : $cos(ang);
        v   = v * (2.0 ** TW_F);
        q   = $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
        return q[TW_W-1:0];
    endfunction

    logic signed [TW_W-1:0] tab_re [ENTRIES];
    logic signed [TW_W-1:0] tab_im [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_tab
        assign tab_re[i] = coef(i << STAGE, 1'b0);
        assign tab_im[i] = coef(i << STAGE, 1'b1);
    end

    assign w_re = tab_re[idx];
    assign w_im = tab_im[idx];
endmodule

// File: rtl/sdf_delay_mem.sv
module sdf_delay_mem #(
    parameter int AW = 3,
    parameter int W  = 36
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/sdf_butterfly.sv
module sdf_butterfly
    import sdf_pkg::*;
#(
    parameter int TW_W = 18,
    parameter int TW_F = 16
) (
    input  cplx_t                  a,
    input  cplx_t                  b,
    input  logic signed [TW_W-1:0] w_re,
    input  logic signed [TW_W-1:0] w_im,
    output cplx_t                  sum_o,
    output cplx_t                  dif_o
);
    wide_t ar, ai, br, bi, wr, wi;
    wide_t sr, si, dr, di, pr, pi, qr, qi, rnd;
    logic  hi_r, lo_r, hi_i, lo_i;

    always_comb begin
        ar = widen(a.re);
        ai = widen(a.im);
        br = widen(b.re);
        bi = widen(b.im);
        wr = {{(WIDE-TW_W){w_re[TW_W-1]}}, w_re};
        wi = {{(WIDE-TW_W){w_im[TW_W-1]}}, w_im};
        rnd = {{(WIDE-1){1'b0}}, 1'b1} <<< TW_F;

        sr = (ar + br + 1) >>> 1;
        si = (ai + bi + 1) >>> 1;
        sum_o.re = sr[DW-1:0];
        sum_o.im = si[DW-1:0];

        dr = ar - br;
        di = ai - bi;
        pr = dr * wr - di * wi;
        pi = dr * wi + di * wr;
        qr = (pr + rnd) >>> (TW_F + 1);
        qi = (pi + rnd) >>> (TW_F + 1);

        hi_r = qr > WMAX;
        lo_r = qr < WMIN;
        hi_i = qi > WMAX;
        lo_i = qi < WMIN;

        dif_o.re = clamp(qr);
        dif_o.im = clamp(qi);
    end

    always_comb begin
        if (hi_r) p_clamp_hi_re_r5: assert (dif_o.re == SMAX) else $error("clamp hi re");
        if (lo_r) p_clamp_lo_re_r5: assert (dif_o.re == SMIN) else $error("clamp lo re");
        if (hi_i) p_clamp_hi_im_r5: assert (dif_o.im == SMAX) else $error("clamp hi im");
        if (lo_i) p_clamp_lo_im_r5: assert (dif_o.im == SMIN) else $error("clamp lo im");
    end
endmodule

// File: rtl/sdf_fft_stage.sv
module sdf_fft_stage
    import sdf_pkg::*;
#(
    parameter int LOG2N = 4,
    parameter int STAGE = 0,
    parameter int TW_W  = 18,
    parameter int TW_F  = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [17:0] in_re,
    input  logic [17:0] in_im,
    output logic        out_valid,
    output logic [17:0] out_re,
    output logic [17:0] out_im
);
    localparam int CW = LOG2N - STAGE;
    localparam int AW = (CW > 1) ? CW - 1 : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          primed;
        logic          vld;
        cplx_t         dat;
    } state_t;

    state_t st_d, st_q;

    logic          phase;
    logic [AW-1:0] idx;
    cplx_t         x_in, head, mem_wd, sum_c, dif_c;
    logic          mem_we;
    logic signed [TW_W-1:0] w_re, w_im;

    assign x_in.re = in_re;
    assign x_in.im = in_im;
    assign phase   = st_q.cnt[CW-1];

    if (CW > 1) begin : g_idx
        assign idx = st_q.cnt[AW-1:0];
    end else begin : g_idx1
        assign idx = '0;
    end

    sdf_delay_mem #(.AW(AW), .W(2*DW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (idx),
        .wdata (mem_wd),
        .rdata (head)
    );

    sdf_twiddle_rom #(.LOG2N(LOG2N), .STAGE(STAGE), .AW(AW),
                      .TW_W(TW_W), .TW_F(TW_F)) u_rom (
        .idx  (idx),
        .w_re (w_re),
        .w_im (w_im)
    );

    sdf_butterfly #(.TW_W(TW_W), .TW_F(TW_F)) u_bfly (
        .a     (head),
        .b     (x_in),
        .w_re  (w_re),
        .w_im  (w_im),
        .sum_o (sum_c),
        .dif_o (dif_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        mem_we   = 1'b0;
        mem_wd   = x_in;
        if (in_valid) begin
            st_d.cnt = st_q.cnt + {{(CW-1){1'b0}}, 1'b1};
            mem_we   = 1'b1;
            if (phase) begin
                mem_wd      = dif_c;
                st_d.dat    = sum_c;
                st_d.vld    = 1'b1;
                st_d.primed = 1'b1;
            end else begin
                mem_wd   = x_in;
                st_d.dat = head;
                st_d.vld = st_q.primed;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_re    = st_q.dat.re;
    assign out_im    = st_q.dat.im;

    p_valid_src_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    p_unprimed_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !phase && !st_q.primed) |=> !out_valid);

    p_fill_head_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !phase && st_q.primed) |=>
            (out_re == $past(head.re) && out_im == $past(head.im)));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(st_q.cnt) && $stable(out_re) && $stable(out_im)));

    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (!out_valid && out_re == '0 && out_im == '0));
endmodule

// File: tb/sim_sdf_fft_stage.sv
module sim_sdf_fft_stage;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [17:0] in_re = '0;
    logic [17:0] in_im = '0;
    logic        out_valid;
    logic [17:0] out_re, out_im;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdf_fft_stage #(.LOG2N(4), .STAGE(2)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    // D = 2: a block is 4 beats; twiddles are 1 (n=0) and -j (n=1).
    // columns: in_re, in_im, expected valid, expected re, expected im
    localparam int TV [12][5] = '{
        '{    100,     20, 0,       0,  0},
        '{    -50,     30, 0,       0,  0},
        '{     60,    -40, 1,      80,-10},
        '{     10,     10, 1,     -20, 20},
        '{ 131071,      0, 1,      20, 30},
        '{      0,-131072, 1,      10, 30},
        '{-131072,      0, 1,       0,  0},
        '{      0, 131071, 1,       0,  0},
        '{      0,      0, 1,  131071,  0},
        '{      0,      0, 1, -131071,  0},
        '{      0,      0, 1,       0,  0},
        '{      0,      0, 1,       0,  0}
    };

    function automatic string row_tag(input int i);
        if (i < 2)            return "R2";
        if (i < 4)            return "R1 R3";
        if (i < 6)            return "R4 R8";
        if (i == 8 || i == 9) return "R5";
        return "R3";
    endfunction

    task automatic chk(input string tag, input bit exp_v, input bit chk_data,
                       input int exp_re, input int exp_im);
        int gr, gi;
        gr = int'($signed(out_re));
        gi = int'($signed(out_im));
        checks++;
        if (out_valid !== exp_v || (chk_data && (gr != exp_re || gi != exp_im))) begin
            errors++;
            $display("FAIL %s: got valid=%0b (%0d,%0d) expected valid=%0b (%0d,%0d)",
                     tag, out_valid, gr, gi, exp_v, exp_re, exp_im);
        end
    endtask

    task automatic beat(input int re, input int im);
        @(negedge clk);
        in_valid = 1'b1;
        in_re    = re[17:0];
        in_im    = im[17:0];
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R7 reset state", 1'b0, 1'b1, 0, 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < 12; i++) begin
            beat(TV[i][0], TV[i][1]);
            chk(row_tag(i), TV[i][2] != 0, TV[i][2] != 0, TV[i][3], TV[i][4]);
        end

        // mid-block reset
        beat(5, 5);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R7 clear after mid-block reset", 1'b0, 1'b1, 0, 0);
        @(negedge clk);
        rst = 1'b0;

        beat(1, 0); chk("R2 R7 fill after reset", 1'b0, 1'b0, 0, 0);
        beat(1, 0); chk("R2 R7 fill after reset", 1'b0, 1'b0, 0, 0);
        beat(3, 0); chk("R7 block restarts at position 0", 1'b1, 1'b1, 2, 0);
        beat(1, 0); chk("R3 second pair", 1'b1, 1'b1, 1, 0);

        // stall in the middle of a block
        beat(8, 4);  chk("R4 rounding of negative difference", 1'b1, 1'b1, -1, 0);
        beat(2, -6); chk("R4 zero difference", 1'b1, 1'b1, 0, 0);
        beat(4, 4);  chk("R3 sum before stall", 1'b1, 1'b1, 6, 4);
        idle();      chk("R6 idle holds output", 1'b0, 1'b1, 6, 4);
        idle();      chk("R6 idle holds output", 1'b0, 1'b1, 6, 4);
        beat(0, 2);  chk("R6 pairing kept across stall", 1'b1, 1'b1, 1, -2);
        beat(0, 0);  chk("R1 R4 difference n=0 after stall", 1'b1, 1'b1, 2, 0);
        beat(0, 0);  chk("R4 R8 difference n=1 rotated by -j", 1'b1, 1'b1, -4, -1);
        idle();      chk("R6 no valid on idle", 1'b0, 1'b1, -4, -1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule